// File: doc/BRIEF.md
# Translation-Table Store Redirector

This block sits on one core's store path, between the core and its private cache. It checks the address of every store. A store that lands inside the in-memory translation-cache window is an update to a cached translation. It goes to the cache as a plain coherent write only if the store is privileged. An unprivileged store into that window is consumed and flagged as rejected, and nothing is written. Stores that fall outside every window go straight to the cache in the same cycle, with no state in between.

A store into the reverse-map window is a marker write issued after a host mapping change. Its address is derived from the old host physical page, and its data has no meaning. The block never forwards that store. It reads the reverse-map entry at the store address. The entry holds a valid bit and the set index of the translation-cache entry that maps the page. If the entry is valid, the block writes to that translation-cache line, which makes the coherence fabric invalidate every core's copy of the translation. In the same cycle it clears the reverse-map entry, which keeps the reverse map inclusive of the translation cache. Only one redirect is handled at a time, and the core is held off until it finishes.

Top module: `xlt_store_redirect`

## Requirements
- R1: A store whose address is in neither window appears on the cache port in the same cycle with address and data unchanged and `cw_redir`=0, and `st_ready` follows `cw_ready`.
- R2: A store with `st_priv`=1 and `fwd_base` <= address < `fwd_limit` is forwarded unchanged in the same cycle with `cw_redir`=0.
- R3: A store into the translation-cache window with `st_priv`=0 is accepted (`st_ready`=1) with `st_reject`=1, and `cw_valid` stays 0.
- R4: A store with `inv_base` <= address < `inv_limit` (and outside the translation-cache window) is accepted and never forwarded. In the next cycle `ir_req_valid` pulses for one cycle with `ir_addr` equal to the store address.
- R5: From the acceptance of a reverse-map store until its redirect finishes, `st_ready` is 0 and no core store reaches the cache port. A store held during that time is forwarded once the block is idle again.
- R6: A reverse-map response with bit SET_W = 1 (valid) and bits SET_W-1:0 = set index is followed one cycle later by `cw_valid`=1, `cw_redir`=1, `cw_addr` = `fwd_base` + (set index << 6) and `cw_data`=0. These values are held until `cw_ready`.
- R7: While that redirected write is presented, `ir_clr_valid`=1 with `ir_clr_addr` equal to the reverse-map store address.
- R8: A response with the valid bit at 0 produces no cache write and no clear, and the block returns to idle.
- R9: When the two windows overlap, the translation-cache window takes priority.
- R10: Window bases are inclusive and limits are exclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fwd_base | input | AW | Translation-cache window start (inclusive) |
| fwd_limit | input | AW | Translation-cache window end (exclusive) |
| inv_base | input | AW | Reverse-map window start (inclusive) |
| inv_limit | input | AW | Reverse-map window end (exclusive) |
| st_valid | input | 1 | Core store request |
| st_ready | output | 1 | Store accepted this cycle |
| st_addr | input | AW | Store physical address |
| st_data | input | DW | Store data |
| st_priv | input | 1 | Store may modify translation entries |
| st_reject | output | 1 | Store consumed and dropped by permission check |
| cw_valid | output | 1 | Cache write request |
| cw_ready | input | 1 | Cache accepts write |
| cw_addr | output | AW | Cache write address |
| cw_data | output | DW | Cache write data |
| cw_redir | output | 1 | Write is a redirected translation invalidation |
| ir_req_valid | output | 1 | Reverse-map entry read request |
| ir_addr | output | AW | Reverse-map entry address |
| ir_rsp_valid | input | 1 | Reverse-map read data valid |
| ir_rsp_data | input | SET_W+1 | Entry: valid bit on top, set index below |
| ir_clr_valid | output | 1 | Clear reverse-map entry |
| ir_clr_addr | output | AW | Reverse-map entry to clear |

## Verification
The hardest situation to reach is a second store that arrives while a redirect is in flight and the cache is stalling the redirected write. That is where ordering and back-pressure can go wrong. The stimulus places an ordinary store on the core port right after the reverse-map store is accepted and keeps it there. It then returns a valid entry and holds `cw_ready` low for a cycle. The checks confirm that the held store stays blocked, that the redirected write does not move, and that the held store goes through only after the redirect completes. A second pass returns an invalid entry, and a third moves the reverse-map window so that it overlaps the translation-cache window.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
   typedef enum logic [1:0] {
      RD_IDLE,
      RD_REQ,
      RD_WAIT,
      RD_WRITE
   } redir_state_e;

   typedef enum logic [1:0] {
      CLS_PLAIN,
      CLS_FWD,
      CLS_INV
   } store_cls_e;

   localparam int unsigned NUM_WIN = 2;
   localparam int unsigned WIN_FWD = 0;
   localparam int unsigned WIN_INV = 1;
endpackage

// File: rtl/xlt_window_match.sv
module xlt_window_match #(
   parameter int unsigned AW   = 32,
   parameter int unsigned NWIN = 2
) (
   input  logic [AW-1:0]           addr,
   input  logic [NWIN-1:0][AW-1:0] base,
   input  logic [NWIN-1:0][AW-1:0] limit,
   output logic [NWIN-1:0]         hit
);
   for (genvar w = 0; w < NWIN; w++) begin : g_win
      assign hit[w] = (addr >= base[w]) && (addr < limit[w]);
   end
endmodule

// File: rtl/xlt_redirect_ctl.sv
module xlt_redirect_ctl
   import xlt_pkg::*;
#(
   parameter int unsigned AW         = 32,
   parameter int unsigned SET_W      = 12,
   parameter int unsigned LINE_SHIFT = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [AW-1:0]    start_addr,
   input  logic [AW-1:0]    fwd_base,
   input  logic             rsp_valid,
   input  logic [SET_W:0]   rsp_entry,
   input  logic             wr_ready,
   output logic             busy,
   output logic             rd_req,
   output logic [AW-1:0]    rd_addr,
   output logic             wr_valid,
   output logic [AW-1:0]    wr_addr
);
   redir_state_e state_q;
   logic [AW-1:0] inv_addr_q;
   logic [AW-1:0] tgt_addr_q;
   logic [AW-1:0] set_off;

   assign set_off = AW'(rsp_entry[SET_W-1:0]) << LINE_SHIFT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= RD_IDLE;
         inv_addr_q <= '0;
         tgt_addr_q <= '0;
      end else begin
         unique case (state_q)
            RD_IDLE: if (start) begin
               state_q    <= RD_REQ;
               inv_addr_q <= start_addr;
            end
            RD_REQ: state_q <= RD_WAIT;
            RD_WAIT: if (rsp_valid) begin
               if (rsp_entry[SET_W]) begin
                  state_q    <= RD_WRITE;
                  tgt_addr_q <= fwd_base + set_off;
               end else begin
                  state_q <= RD_IDLE;
               end
            end
            RD_WRITE: if (wr_ready) state_q <= RD_IDLE;
            default: state_q <= RD_IDLE;
         endcase
      end
   end

   assign busy     = (state_q != RD_IDLE);
   assign rd_req   = (state_q == RD_REQ);
   assign rd_addr  = inv_addr_q;
   assign wr_valid = (state_q == RD_WRITE);
   assign wr_addr  = tgt_addr_q;
endmodule

// File: rtl/xlt_store_redirect.sv
module xlt_store_redirect
   import xlt_pkg::*;
#(
   parameter int unsigned AW         = 32,
   parameter int unsigned DW         = 64,
   parameter int unsigned SET_W      = 12,
   parameter int unsigned LINE_SHIFT = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    fwd_base,
   input  logic [AW-1:0]    fwd_limit,
   input  logic [AW-1:0]    inv_base,
   input  logic [AW-1:0]    inv_limit,
   input  logic             st_valid,
   output logic             st_ready,
   input  logic [AW-1:0]    st_addr,
   input  logic [DW-1:0]    st_data,
   input  logic             st_priv,
   output logic             st_reject,
   output logic             cw_valid,
   input  logic             cw_ready,
   output logic [AW-1:0]    cw_addr,
   output logic [DW-1:0]    cw_data,
   output logic             cw_redir,
   output logic             ir_req_valid,
   output logic [AW-1:0]    ir_addr,
   input  logic             ir_rsp_valid,
   input  logic [SET_W:0]   ir_rsp_data,
   output logic             ir_clr_valid,
   output logic [AW-1:0]    ir_clr_addr
);
   localparam int unsigned SPAN_W = SET_W + LINE_SHIFT;

   if (SPAN_W > AW) begin : g_bad_span
      $error("set index plus line offset exceeds address width");
   end
   if (SET_W < 1) begin : g_bad_set
      $error("SET_W must be at least 1");
   end

   logic [NUM_WIN-1:0][AW-1:0] win_base;
   logic [NUM_WIN-1:0][AW-1:0] win_limit;
   logic [NUM_WIN-1:0]         win_hit;
   store_cls_e                 cls;
   logic busy, rd_req, wr_valid;
   logic [AW-1:0] rd_addr, wr_addr;
   logic pass_ok, start;

   assign win_base[WIN_FWD]  = fwd_base;
   assign win_limit[WIN_FWD] = fwd_limit;
   assign win_base[WIN_INV]  = inv_base;
   assign win_limit[WIN_INV] = inv_limit;

   xlt_window_match #(.AW(AW), .NWIN(NUM_WIN)) u_match (
      .addr  (st_addr),
      .base  (win_base),
      .limit (win_limit),
      .hit   (win_hit)
   );

   always_comb begin
      if (win_hit[WIN_FWD])      cls = CLS_FWD;
      else if (win_hit[WIN_INV]) cls = CLS_INV;
      else                       cls = CLS_PLAIN;
   end

   assign pass_ok   = (cls == CLS_PLAIN) || ((cls == CLS_FWD) && st_priv);
   assign st_reject = !busy && st_valid && (cls == CLS_FWD) && !st_priv;
   assign start     = !busy && st_valid && (cls == CLS_INV);
   assign st_ready  = !busy && (pass_ok ? cw_ready : 1'b1);

   xlt_redirect_ctl #(.AW(AW), .SET_W(SET_W), .LINE_SHIFT(LINE_SHIFT)) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_addr (st_addr),
      .fwd_base   (fwd_base),
      .rsp_valid  (ir_rsp_valid),
      .rsp_entry  (ir_rsp_data),
      .wr_ready   (cw_ready),
      .busy       (busy),
      .rd_req     (rd_req),
      .rd_addr    (rd_addr),
      .wr_valid   (wr_valid),
      .wr_addr    (wr_addr)
   );

   assign cw_valid     = busy ? wr_valid : (st_valid && pass_ok);
   assign cw_addr      = busy ? wr_addr : st_addr;
   assign cw_data      = busy ? '0 : st_data;
   assign cw_redir     = busy;
   assign ir_req_valid = rd_req;
   assign ir_addr      = rd_addr;
   assign ir_clr_valid = wr_valid;
   assign ir_clr_addr  = rd_addr;
endmodule

// File: rtl/xlt_store_redirect_chk.sv
module xlt_store_redirect_chk #(
   parameter int unsigned AW    = 32,
   parameter int unsigned DW    = 64
) (
   input logic          clk,
   input logic          rst_n,
   input logic          st_valid,
   input logic          st_ready,
   input logic [AW-1:0] st_addr,
   input logic          st_reject,
   input logic          cw_valid,
   input logic          cw_ready,
   input logic [AW-1:0] cw_addr,
   input logic [DW-1:0] cw_data,
   input logic          cw_redir,
   input logic          ir_req_valid,
   input logic          ir_clr_valid
);
   AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      st_reject |-> (!cw_valid && st_ready)) else $error("reject wrote");            // R3
   AST_PLAIN_FROM_CORE: assert property (@(posedge clk) disable iff (!rst_n)
      (cw_valid && !cw_redir) |-> (st_valid && cw_addr == st_addr)) else $error("plain path");  // R1
   AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ir_req_valid |=> !ir_req_valid) else $error("read not a pulse");            // R4
   AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      ir_req_valid |-> !st_ready) else $error("accepted while reading");           // R5
   AST_REDIR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (cw_valid && cw_redir) |-> (cw_data == '0)) else $error("dummy data leaked"); // R6
   AST_REDIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cw_valid && cw_redir && !cw_ready) |=> (cw_valid && cw_redir && $stable(cw_addr)))
      else $error("redirect dropped");                                             // R6
   AST_CLR_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
      ir_clr_valid |-> (cw_valid && cw_redir)) else $error("clear unpaired");      // R7
endmodule

bind xlt_store_redirect xlt_store_redirect_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .st_valid     (st_valid),
   .st_ready     (st_ready),
   .st_addr      (st_addr),
   .st_reject    (st_reject),
   .cw_valid     (cw_valid),
   .cw_ready     (cw_ready),
   .cw_addr      (cw_addr),
   .cw_data      (cw_data),
   .cw_redir     (cw_redir),
   .ir_req_valid (ir_req_valid),
   .ir_clr_valid (ir_clr_valid)
);

// File: tb/sim_xlt_store_redirect.sv
module sim_xlt_store_redirect;
   localparam int unsigned AW = 32;
   localparam int unsigned DW = 64;
   localparam int unsigned SW = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] fwd_base = 32'h1000_0000, fwd_limit = 32'h1004_0000;
   logic [AW-1:0] inv_base = 32'h2000_0000, inv_limit = 32'h2001_0000;
   logic st_valid = 1'b0, st_priv = 1'b0, cw_ready = 1'b1, ir_rsp_valid = 1'b0;
   logic [AW-1:0] st_addr = '0;
   logic [DW-1:0] st_data = '0;
   logic [SW:0]   ir_rsp_data = '0;
   logic st_ready, st_reject, cw_valid, cw_redir, ir_req_valid, ir_clr_valid;
   logic [AW-1:0] cw_addr, ir_addr, ir_clr_addr;
   logic [DW-1:0] cw_data;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   xlt_store_redirect #(.AW(AW), .DW(DW), .SET_W(SW), .LINE_SHIFT(6)) u0 (
      .clk(clk), .rst_n(rst_n), .fwd_base(fwd_base), .fwd_limit(fwd_limit),
      .inv_base(inv_base), .inv_limit(inv_limit), .st_valid(st_valid),
      .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data), .st_priv(st_priv),
      .st_reject(st_reject), .cw_valid(cw_valid), .cw_ready(cw_ready),
      .cw_addr(cw_addr), .cw_data(cw_data), .cw_redir(cw_redir),
      .ir_req_valid(ir_req_valid), .ir_addr(ir_addr), .ir_rsp_valid(ir_rsp_valid),
      .ir_rsp_data(ir_rsp_data), .ir_clr_valid(ir_clr_valid), .ir_clr_addr(ir_clr_addr)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   typedef struct packed {
      logic [31:0] addr;
      logic        priv;
      logic        rdy;
      logic        e_valid;
      logic        e_ready;
      logic        e_rej;
   } vec_t;

   // R1 plain, R2 privileged forward, R3 reject, R10 window edges
   localparam vec_t TBL [8] = '{
      '{32'h0000_1000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},  // R1
      '{32'h0000_1000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R1 back-pressure
      '{32'h1000_0000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},  // R2 / R10 base
      '{32'h1003_FFC0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},  // R2 / R10 last line
      '{32'h1004_0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},  // R10 limit is outside
      '{32'h1000_0040, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R3
      '{32'h0FFF_FFC0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},  // R10 below base
      '{32'h2001_0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}   // R10 reverse limit
   };

   initial begin
      repeat (3000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #5;
      chk("reset cw_valid", 64'(cw_valid), 64'd0);
      chk("reset ir_req_valid", 64'(ir_req_valid), 64'd0);
      chk("reset ir_clr_valid", 64'(ir_clr_valid), 64'd0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         st_valid = 1'b1; st_addr = TBL[i].addr; st_priv = TBL[i].priv;
         cw_ready = TBL[i].rdy; st_data = 64'hA5A5_0000 + 64'(i);
         #5;
         chk($sformatf("vec%0d cw_valid", i), 64'(cw_valid), 64'(TBL[i].e_valid));
         chk($sformatf("vec%0d st_ready", i), 64'(st_ready), 64'(TBL[i].e_ready));
         chk($sformatf("vec%0d st_reject", i), 64'(st_reject), 64'(TBL[i].e_rej));
         if (TBL[i].e_valid) begin
            chk($sformatf("vec%0d cw_addr", i), 64'(cw_addr), 64'(TBL[i].addr));
            chk($sformatf("vec%0d cw_data", i), cw_data, 64'hA5A5_0000 + 64'(i));
            chk($sformatf("vec%0d cw_redir", i), 64'(cw_redir), 64'd0);
         end
      end
      @(negedge clk);
      st_valid = 1'b0; cw_ready = 1'b1;

      // R4: reverse-map store is accepted but not forwarded
      @(negedge clk);
      st_valid = 1'b1; st_addr = 32'h2000_0100; st_data = 64'hDEAD; st_priv = 1'b0;
      #5;
      chk("R4 accept", 64'(st_ready), 64'd1);
      chk("R4 no forward", 64'(cw_valid), 64'd0);
      @(negedge clk);
      st_addr = 32'h0000_2000; st_data = 64'h55;   // held plain store
      #5;
      chk("R4 read req", 64'(ir_req_valid), 64'd1);
      chk("R4 read addr", 64'(ir_addr), 64'h2000_0100);
      chk("R5 blocked in read", 64'(st_ready), 64'd0);
      chk("R5 no cache write", 64'(cw_valid), 64'd0);
      @(negedge clk);
      #5;
      chk("R4 pulse ends", 64'(ir_req_valid), 64'd0);
      chk("R5 blocked in wait", 64'(st_ready), 64'd0);
      ir_rsp_valid = 1'b1; ir_rsp_data = {1'b1, 12'h005}; cw_ready = 1'b0;
      @(negedge clk);
      ir_rsp_valid = 1'b0;
      #5;
      chk("R6 redirect valid", 64'(cw_valid), 64'd1);
      chk("R6 redirect flag", 64'(cw_redir), 64'd1);
      chk("R6 redirect addr", 64'(cw_addr), 64'h1000_0140);
      chk("R6 redirect data", cw_data, 64'd0);
      chk("R7 clear valid", 64'(ir_clr_valid), 64'd1);
      chk("R7 clear addr", 64'(ir_clr_addr), 64'h2000_0100);
      chk("R5 blocked in write", 64'(st_ready), 64'd0);
      @(negedge clk);
      #5;
      chk("R6 held on stall", 64'(cw_valid), 64'd1);
      chk("R6 addr held", 64'(cw_addr), 64'h1000_0140);
      cw_ready = 1'b1;
      @(negedge clk);
      #5;
      chk("R5 held store passes", 64'(cw_valid), 64'd1);
      chk("R5 held store addr", 64'(cw_addr), 64'h0000_2000);
      chk("R5 held store kind", 64'(cw_redir), 64'd0);
      chk("R5 ready again", 64'(st_ready), 64'd1);
      chk("R7 clear done", 64'(ir_clr_valid), 64'd0);

      // R8: invalid entry suppresses the redirect
      @(negedge clk);
      st_addr = 32'h2000_0200;
      @(negedge clk);
      st_valid = 1'b0;
      @(negedge clk);
      ir_rsp_valid = 1'b1; ir_rsp_data = {1'b0, 12'h007};
      @(negedge clk);
      ir_rsp_valid = 1'b0;
      #5;
      chk("R8 no write", 64'(cw_valid), 64'd0);
      chk("R8 no clear", 64'(ir_clr_valid), 64'd0);
      chk("R8 idle again", 64'(st_ready), 64'd1);

      // R9: overlapping windows, translation window wins
      @(negedge clk);
      inv_base = 32'h1003_0000; inv_limit = 32'h1004_0000;
      st_valid = 1'b1; st_addr = 32'h1003_0040; st_priv = 1'b1; st_data = 64'h77;
      #5;
      chk("R9 forwarded", 64'(cw_valid), 64'd1);
      chk("R9 not redirect", 64'(cw_redir), 64'd0);
      @(negedge clk);
      st_priv = 1'b0;
      #5;
      chk("R9 no read started", 64'(ir_req_valid), 64'd0);
      chk("R9 unprivileged rejects", 64'(st_reject), 64'd1);
      @(negedge clk);
      st_valid = 1'b0;
      #5;
      chk("R9 no read after reject", 64'(ir_req_valid), 64'd0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule